// File: doc/BRIEF.md
# Low-Battery Gain Reduction Supervisor

This block lowers the output gain of an audio path in steps as its battery sags, and gives the gain back in steps as the supply recovers. It does not measure voltage itself. Analog comparators supply active-high flags: three for the instantaneous supply and two for the averaged supply. A one-second tick paces every timed decision. The block reports the total attenuation in dB, which the gain stage applies, and a mute flag.

Two counters work side by side and neither one touches the other. The dip counter reacts at once to short sags below 0.95 V in 3 dB steps, at most two of them. After each step it stops watching for a hold-off window. It restores gain only after the supply has stayed healthy for a whole window. The level counter follows the average supply in 1 dB steps, one per step period. It saturates and then mutes while the average stays low. It unmutes and then winds back down while the average stays high.

Top module: `lowbat_gain_sup`

## Requirements
- R1: After reset `atten_db` is 0 and `mute` is 0.
- R2: When `inst_below_lo` is 1, `avg_below_lo` is 0, no hold-off is running and fewer than INST_MAX dip steps are held, the dip count rises by one on the next clock. This adds INST_DB (3) dB.
- R3: Each dip step starts a hold-off of HOLD_SEC ticks. During the hold-off, dips have no effect on `atten_db`.
- R4: A dip that arrives after the hold-off, with one step held, adds a second step (6 dB in total) and starts a new hold-off. The dip count never goes above INST_MAX (2).
- R5: Once the hold-off is over, if `inst_above_hi` stays 1 for HOLD_SEC consecutive ticks, the dip count returns to 0. A cycle with `inst_above_hi` at 0 restarts this count. `inst_above_mid` on its own never clears a single step.
- R6: Once the hold-off is over, with INST_MAX steps held, if `inst_above_mid` stays 1 for HOLD_SEC consecutive ticks, the dip count drops by one.
- R7: While `avg_below_lo` is 1, the level count rises by one every STEP_SEC ticks, up to AVG_MAX. The level count changes only in cycles that carry a tick.
- R8: If the level count is already at AVG_MAX and another STEP_SEC ticks pass with `avg_below_lo` at 1, `mute` goes to 1. `mute` is 1 only while the level count equals AVG_MAX.
- R9: When `avg_above_hi` is 1 (and `avg_below_lo` is 0), `mute` is 0 from the next clock onward. The level count then falls by one every STEP_SEC ticks and stops at 0.
- R10: While both average flags are 0, the level count and `mute` do not change.
- R11: A dip while `avg_below_lo` is 1 is ignored.
- R12: When the average direction changes (down, idle or up), the step timer starts again from zero. The first step in the new direction comes a full STEP_SEC ticks later.
- R13: `atten_db` equals INST_DB times the dip count plus the level count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| inst_below_lo | input | 1 | Instantaneous supply under 0.95 V |
| inst_above_mid | input | 1 | Instantaneous supply over 1.0 V |
| inst_above_hi | input | 1 | Instantaneous supply over 1.1 V |
| avg_below_lo | input | 1 | Average supply under 0.95 V |
| avg_above_hi | input | 1 | Average supply over 1.1 V |
| atten_db | output | DW | Total attenuation in dB |
| mute | output | 1 | Output muted |

## Verification
The hardest state to reach is a second dip step followed by partial recovery. The dip must be held through the whole hold-off, so that it lands on the first cycle the dip detector is armed again. Then the supply must sit in the 1.0 to 1.1 V band for a full window. The bench holds the dip flag across the hold-off ticks, which produces 6 dB. It then counts ticks with only the middle flag set and checks that the count steps back to 3 dB and stops there. The timer restart is checked the same way: the bench reverses the average direction with a partial step period already accumulated, and a step that arrives one tick too early shows as a failure.

// File: rtl/lowbat_gain_sup.sv
`timescale 1ns/1ps
module lowbat_gain_sup #(
  parameter int HOLD_SEC = 30,
  parameter int STEP_SEC = 10,
  parameter int AVG_MAX  = 18,
  parameter int INST_MAX = 2,
  parameter int INST_DB  = 3,
  localparam int HW = $clog2(HOLD_SEC + 1),
  localparam int SW = $clog2(STEP_SEC + 1),
  localparam int AW = $clog2(AVG_MAX + 1),
  localparam int IW = $clog2(INST_MAX + 1),
  localparam int DW = $clog2(INST_MAX * INST_DB + AVG_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic          inst_below_lo,
  input  logic          inst_above_mid,
  input  logic          inst_above_hi,
  input  logic          avg_below_lo,
  input  logic          avg_above_hi,
  output logic [DW-1:0] atten_db,
  output logic          mute
);
  typedef enum logic [1:0] {DIR_IDLE, DIR_DOWN, DIR_UP} dir_t;

  logic [IW-1:0] inst_cnt;
  logic [HW-1:0] hold_left, hi_run, mid_run;
  logic [AW-1:0] avg_cnt;
  logic [SW-1:0] step_t;
  dir_t          dir, dir_q;
  logic          mute_q;

  wire armed    = (hold_left == '0);
  wire dip      = armed && inst_below_lo && !avg_below_lo && (inst_cnt < IW'(INST_MAX));
  wire hi_done  = inst_above_hi && sec_tick && (inst_cnt != '0) && (hi_run == HW'(HOLD_SEC - 1));
  wire mid_done = inst_above_mid && sec_tick && (inst_cnt == IW'(INST_MAX)) &&
                  (mid_run == HW'(HOLD_SEC - 1));
  wire step_due = sec_tick && (step_t == SW'(STEP_SEC - 1));

  assign dir = avg_below_lo ? DIR_DOWN : (avg_above_hi ? DIR_UP : DIR_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inst_cnt  <= '0;
      hold_left <= '0;
      hi_run    <= '0;
      mid_run   <= '0;
    end else if (dip) begin
      inst_cnt  <= inst_cnt + 1'b1;
      hold_left <= HW'(HOLD_SEC);
      hi_run    <= '0;
      mid_run   <= '0;
    end else if (!armed) begin
      if (sec_tick) hold_left <= hold_left - 1'b1;
      hi_run  <= '0;
      mid_run <= '0;
    end else if (hi_done) begin
      inst_cnt <= '0;
      hi_run   <= '0;
      mid_run  <= '0;
    end else if (mid_done) begin
      inst_cnt <= inst_cnt - 1'b1;
      hi_run   <= '0;
      mid_run  <= '0;
    end else begin
      if (!inst_above_hi || inst_cnt == '0) hi_run <= '0;
      else if (sec_tick)                    hi_run <= hi_run + 1'b1;
      if (!inst_above_mid || inst_cnt != IW'(INST_MAX)) mid_run <= '0;
      else if (sec_tick)                                mid_run <= mid_run + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avg_cnt <= '0;
      step_t  <= '0;
      mute_q  <= 1'b0;
      dir_q   <= DIR_IDLE;
    end else begin
      dir_q <= dir;
      if (dir != dir_q) begin
        step_t <= '0;
        if (dir == DIR_UP) mute_q <= 1'b0;
      end else if (dir == DIR_IDLE) begin
        step_t <= '0;
      end else if (step_due) begin
        step_t <= '0;
        if (dir == DIR_DOWN) begin
          if (avg_cnt < AW'(AVG_MAX)) avg_cnt <= avg_cnt + 1'b1;
          else                        mute_q  <= 1'b1;
        end else if (avg_cnt != '0) begin
          avg_cnt <= avg_cnt - 1'b1;
        end
      end else if (sec_tick) begin
        step_t <= step_t + 1'b1;
      end
    end
  end

  assign atten_db = DW'(inst_cnt) * DW'(INST_DB) + DW'(avg_cnt);
  assign mute     = mute_q;
endmodule

module lowbat_gain_sup_chk #(
  parameter int AVG_MAX  = 18,
  parameter int INST_MAX = 2,
  parameter int IW = 2,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_tick,
  input logic          avg_below_lo,
  input logic          avg_above_hi,
  input logic          mute,
  input logic [IW-1:0] inst_cnt,
  input logic [AW-1:0] avg_cnt
);
  a_r4_inst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    inst_cnt <= IW'(INST_MAX));
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_cnt > $past(inst_cnt)) |-> (inst_cnt == $past(inst_cnt) + 1'b1));
  a_r7_avg_cap: assert property (@(posedge clk) disable iff (!rst_n)
    avg_cnt <= AW'(AVG_MAX));
  a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_cnt != $past(avg_cnt)) |-> $past(sec_tick));
  a_r8_mute_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> (avg_cnt == AW'(AVG_MAX)));
  a_r9_up_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
    $past(avg_above_hi && !avg_below_lo) |-> (!mute && avg_cnt <= $past(avg_cnt)));
  a_r10_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!avg_below_lo && !avg_above_hi) |-> (avg_cnt == $past(avg_cnt) && mute == $past(mute)));
  a_r11_dip_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $past(avg_below_lo) |-> (inst_cnt <= $past(inst_cnt)));
endmodule

bind lowbat_gain_sup lowbat_gain_sup_chk #(
  .AVG_MAX(AVG_MAX), .INST_MAX(INST_MAX), .IW(IW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
  .avg_below_lo(avg_below_lo), .avg_above_hi(avg_above_hi),
  .mute(mute), .inst_cnt(inst_cnt), .avg_cnt(avg_cnt)
);

// File: tb/sim_lowbat_gain_sup.sv
`timescale 1ns/1ps
module sim_lowbat_gain_sup;
  localparam int HOLD = 3;
  localparam int STEP = 2;
  localparam int AMAX = 4;
  localparam int DW   = $clog2(2 * 3 + AMAX + 1);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic ilo = 1'b0, imid = 1'b1, ihi = 1'b1, alo = 1'b0, ahi = 1'b0;
  logic [DW-1:0] atten;
  logic mute;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lowbat_gain_sup #(.HOLD_SEC(HOLD), .STEP_SEC(STEP), .AVG_MAX(AMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(tick),
    .inst_below_lo(ilo), .inst_above_mid(imid), .inst_above_hi(ihi),
    .avg_below_lo(alo), .avg_above_hi(ahi), .atten_db(atten), .mute(mute));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  function automatic int imin(input int a, input int b); return a < b ? a : b; endfunction
  function automatic int imax(input int a, input int b); return a > b ? a : b; endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    chk(atten, 0, "R1 reset atten");
    chk(mute, 0, "R1 reset mute");
    rst_n = 1'b1; cyc(1);

    // R7, R8: ramp down with average low
    alo = 1'b1; cyc(1);
    for (int k = 1; k <= (AMAX + 2) * STEP; k++) begin
      pulse();
      chk(atten, imin(k / STEP, AMAX), "R7 ramp");
      chk(mute, (k / STEP > AMAX) ? 1 : 0, "R8 mute");
    end

    // R10: middle band holds everything
    alo = 1'b0; cyc(1);
    for (int k = 0; k < 3 * STEP; k++) pulse();
    chk(atten, AMAX, "R10 band atten");
    chk(mute, 1, "R10 band mute");

    // R9: unmute first, then step back
    ahi = 1'b1; cyc(1);
    chk(mute, 0, "R9 unmute");
    chk(atten, AMAX, "R9 unmute no step");
    for (int k = 1; k <= 2 * STEP + 1; k++) begin
      pulse();
      chk(atten, AMAX - k / STEP, "R9 restore");
    end

    // R12: direction change restarts the step timer
    ahi = 1'b0; alo = 1'b1; cyc(1);
    for (int k = 1; k < STEP; k++) begin
      pulse();
      chk(atten, AMAX - 2, "R12 restart");
    end
    pulse();
    chk(atten, AMAX - 1, "R12 full period");

    alo = 1'b0; ahi = 1'b1; cyc(1);
    for (int k = 1; k <= (AMAX + 2) * STEP; k++) begin
      pulse();
      chk(atten, imax(AMAX - 1 - k / STEP, 0), "R9 floor");
    end
    ahi = 1'b0; cyc(1);

    // R2, R3, R4: dips with hold-off
    imid = 1'b0; ihi = 1'b0; ilo = 1'b1; cyc(1);
    chk(atten, 3, "R2 first dip");
    for (int k = 1; k <= HOLD; k++) begin
      pulse();
      chk(atten, 3, "R3 holdoff");
    end
    cyc(1);
    chk(atten, 6, "R4 second dip");
    for (int k = 1; k <= HOLD + 1; k++) begin
      pulse();
      chk(atten, 6, "R4 cap");
    end

    // R6: middle band restores one step
    ilo = 1'b0; imid = 1'b1; cyc(1);
    for (int k = 1; k <= HOLD; k++) begin
      pulse();
      chk(atten, (k == HOLD) ? 3 : 6, "R6 partial restore");
    end
    for (int k = 0; k < 2 * HOLD; k++) pulse();
    chk(atten, 3, "R5 mid alone keeps step");

    // R5: high band with an interruption
    ihi = 1'b1; cyc(1);
    for (int k = 1; k < HOLD; k++) pulse();
    ihi = 1'b0; cyc(1); ihi = 1'b1; cyc(1);
    for (int k = 1; k < HOLD; k++) pulse();
    chk(atten, 3, "R5 interrupted");
    pulse();
    chk(atten, 0, "R5 full restore");

    // R11: dip ignored while the average is low
    imid = 1'b0; ihi = 1'b0; alo = 1'b1; ilo = 1'b1; cyc(2);
    chk(atten, 0, "R11 gated dip");
    ilo = 1'b0; alo = 1'b0; cyc(1);

    // R13: both counters add up independently
    ilo = 1'b1; cyc(1); ilo = 1'b0;
    chk(atten, 3, "R2 dip again");
    alo = 1'b1; cyc(1);
    for (int k = 1; k <= 3 * STEP; k++) begin
      pulse();
      chk(atten, 3 + imin(k / STEP, AMAX), "R13 sum");
    end

    // R1: reset mid-run
    rst_n = 1'b0; cyc(2);
    chk(atten, 0, "R1 re-reset atten");
    chk(mute, 0, "R1 re-reset mute");
    finish_run();
  end
endmodule